// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Overflow Flag

This block is a 32-bit arithmetic unit whose result is registered at its outputs. It provides several operations. Signed and unsigned add and subtract clamp at the edge of their range instead of wrapping. A signed doubling clamps the same way. Saturation to a programmable bit width can be applied to a whole word or to two packed halfwords side by side. One more operation is a plain wrapping add: it never clamps, but it still reports signed overflow.

Every clamp event, and every overflow of the wrapping add, sets one sticky overflow flag. The flag stays set until software pulses the clear input. The operation is selected every cycle by a 4-bit code. Codes with no operation assigned act as an idle pass of the first operand.

Top module: `sat_arith_unit`

## Requirements
- R1: While reset is asserted (`rst_n` low), `result` is 0 and `sat_flag` is 0.
- R2: Code 1 (signed add) and code 2 (signed subtract) detect overflow from operand and result signs. On overflow the result is 0x7FFFFFFF when `opnd_a` is non-negative and 0x80000000 when it is negative, and the flag is set. Otherwise the result is the plain sum or difference.
- R3: Code 3 (unsigned add) gives 0xFFFFFFFF and sets the flag when the sum wraps. Code 4 (unsigned subtract) gives 0 and sets the flag when `opnd_b` exceeds `opnd_a`.
- R4: Code 5 (signed doubling of `opnd_a`) gives 0x7FFFFFFF for inputs of 0x40000000 and above, and 0x80000000 for inputs of 0xC0000000 and below, with the flag set in both cases. Any other input is shifted left by one.
- R5: Code 6 (wrapping add) always returns the modulo-2^32 sum and sets the flag on signed overflow.
- R6: Code 7 saturates signed `opnd_a` to width w = `sat_width`. When the value shifted arithmetically right by w is above 0, the result is 2^w−1. When that shifted value is below −1, the result is the complement of 2^w−1. Both cases set the flag.
- R7: Code 8 saturates `opnd_a` as unsigned to width w. A negative input gives 0, an input above 2^w−1 gives 2^w−1, and both set the flag.
- R8: Code 9 (signed) and code 10 (unsigned) apply the R6 and R7 rules separately to the sign-extended low half (bits 15:0) and high half (bits 31:16) of `opnd_a`. Each 16-bit result goes back into the half it came from. A clamp in either half sets the flag.
- R9: The flag holds its value until `flag_clr` is high for a cycle with no new event. An event in the same cycle as a clear leaves the flag set.
- R10: Codes 0 and 11–15 output `opnd_a` unchanged and leave the flag as it was.
- R11: `result` and `sat_flag` change only at a rising clock edge, one edge after the inputs that produce them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sat_width | input | 5 | Saturation width for codes 7–10 |
| flag_clr | input | 1 | Clear strobe for the sticky flag |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky overflow flag |

## Verification
Both `result` and `sat_flag` are due one rising edge after their inputs, because a single register stage sits between the inputs and each output. The bench drives its inputs on a falling edge and reads the outputs on the following falling edge, which is half a period after the update. One latency check also reads `result` just after the inputs change and before the edge, to confirm it still holds the old value. Clear checks read `sat_flag` at the same one-edge delay. The bench inserts an idle pass cycle between scenarios, so each result is attributed to a single operation.

// File: rtl/sat_arith_pkg.sv
package sat_arith_pkg;

    typedef enum logic [3:0] {
        OP_PASS  = 4'd0,
        OP_SADD  = 4'd1,
        OP_SSUB  = 4'd2,
        OP_UADD  = 4'd3,
        OP_USUB  = 4'd4,
        OP_DBL   = 4'd5,
        OP_WADD  = 4'd6,
        OP_SSATW = 4'd7,
        OP_USATW = 4'd8,
        OP_SSATH = 4'd9,
        OP_USATH = 4'd10
    } sat_op_e;

    function automatic logic op_is_defined(input logic [3:0] code);
        return (code >= 4'd1) && (code <= 4'd10);
    endfunction

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum_raw,
    output logic [W-1:0] sadd_res,
    output logic         sadd_ov,
    output logic [W-1:0] ssub_res,
    output logic         ssub_ov,
    output logic [W-1:0] uadd_res,
    output logic         uadd_ov,
    output logic [W-1:0] usub_res,
    output logic         usub_ov,
    output logic [W-1:0] dbl_res,
    output logic         dbl_ov
);
    localparam logic [W-1:0] SMAX   = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN   = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] DBL_HI = {2'b01, {(W-2){1'b0}}};
    localparam logic [W-1:0] DBL_LO = {2'b11, {(W-2){1'b0}}};

    logic [W-1:0] diff;
    logic [W-1:0] s_clamp;

    always_comb begin
        sum_raw  = a + b;
        diff     = a - b;
        s_clamp  = a[W-1] ? SMIN : SMAX;

        sadd_ov  = (sum_raw[W-1] ^ a[W-1]) & ~(a[W-1] ^ b[W-1]);
        sadd_res = sadd_ov ? s_clamp : sum_raw;

        ssub_ov  = (diff[W-1] ^ a[W-1]) & (a[W-1] ^ b[W-1]);
        ssub_res = ssub_ov ? s_clamp : diff;

        uadd_ov  = (sum_raw < a);
        uadd_res = uadd_ov ? {W{1'b1}} : sum_raw;

        usub_ov  = (diff > a);
        usub_res = usub_ov ? '0 : diff;

        if ($signed(a) >= $signed(DBL_HI)) begin
            dbl_res = SMAX;
            dbl_ov  = 1'b1;
        end else if ($signed(a) <= $signed(DBL_LO)) begin
            dbl_res = SMIN;
            dbl_ov  = 1'b1;
        end else begin
            dbl_res = {a[W-2:0], 1'b0};
            dbl_ov  = 1'b0;
        end
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int W    = 32,
    parameter int SH_W = 5
) (
    input  logic [W-1:0]    val,
    input  logic [SH_W-1:0] width,
    input  logic            is_signed,
    output logic [W-1:0]    res,
    output logic            hit
);
    logic [W-1:0] mask;
    logic [W-1:0] top;
    logic         top_pos;
    logic         top_low;

    always_comb begin
        mask    = ~({W{1'b1}} << width);
        top     = $signed(val) >>> width;
        top_pos = ~top[W-1] & (top != '0);
        top_low = top[W-1] & (top != {W{1'b1}});
        res     = val;
        hit     = 1'b0;
        if (is_signed) begin
            if (top_pos) begin
                res = mask;
                hit = 1'b1;
            end else if (top_low) begin
                res = ~mask;
                hit = 1'b1;
            end
        end else begin
            if (val[W-1]) begin
                res = '0;
                hit = 1'b1;
            end else if ((val & ~mask) != '0) begin
                res = mask;
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= set_i | (flag_q & ~clr_i);
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
    import sat_arith_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [3:0]                  op_sel,
    input  logic [DATA_W-1:0]           opnd_a,
    input  logic [DATA_W-1:0]           opnd_b,
    input  logic [$clog2(DATA_W)-1:0]   sat_width,
    input  logic                        flag_clr,
    output logic [DATA_W-1:0]           result,
    output logic                        sat_flag
);
    localparam int SH_W  = $clog2(DATA_W);
    localparam int NLANE = 2;
    localparam int HW    = DATA_W / NLANE;

    logic [DATA_W-1:0] sum_raw, sadd_res, ssub_res, uadd_res, usub_res, dbl_res;
    logic              sadd_ov, ssub_ov, uadd_ov, usub_ov, dbl_ov;
    logic [DATA_W-1:0] word_res;
    logic              word_hit;
    logic [DATA_W-1:0] half_res;
    logic [NLANE-1:0]  half_hit;
    logic [DATA_W-1:0] nxt_res;
    logic              nxt_evt;
    logic [DATA_W-1:0] res_q;

    sat_addsub #(.W(DATA_W)) u_addsub (
        .a        (opnd_a),
        .b        (opnd_b),
        .sum_raw  (sum_raw),
        .sadd_res (sadd_res),
        .sadd_ov  (sadd_ov),
        .ssub_res (ssub_res),
        .ssub_ov  (ssub_ov),
        .uadd_res (uadd_res),
        .uadd_ov  (uadd_ov),
        .usub_res (usub_res),
        .usub_ov  (usub_ov),
        .dbl_res  (dbl_res),
        .dbl_ov   (dbl_ov)
    );

    sat_clamp #(.W(DATA_W), .SH_W(SH_W)) u_word_clamp (
        .val       (opnd_a),
        .width     (sat_width),
        .is_signed (op_sel == OP_SSATW),
        .res       (word_res),
        .hit       (word_hit)
    );

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            sat_clamp #(.W(HW), .SH_W(SH_W)) u_half_clamp (
                .val       (opnd_a[g*HW +: HW]),
                .width     (sat_width),
                .is_signed (op_sel == OP_SSATH),
                .res       (half_res[g*HW +: HW]),
                .hit       (half_hit[g])
            );
        end
    endgenerate

    always_comb begin
        nxt_res = opnd_a;
        nxt_evt = 1'b0;
        case (op_sel)
            OP_SADD:  begin nxt_res = sadd_res; nxt_evt = sadd_ov; end
            OP_SSUB:  begin nxt_res = ssub_res; nxt_evt = ssub_ov; end
            OP_UADD:  begin nxt_res = uadd_res; nxt_evt = uadd_ov; end
            OP_USUB:  begin nxt_res = usub_res; nxt_evt = usub_ov; end
            OP_DBL:   begin nxt_res = dbl_res;  nxt_evt = dbl_ov;  end
            OP_WADD:  begin nxt_res = sum_raw;  nxt_evt = sadd_ov; end
            OP_SSATW, OP_USATW: begin nxt_res = word_res; nxt_evt = word_hit; end
            OP_SSATH, OP_USATH: begin nxt_res = half_res; nxt_evt = |half_hit; end
            default:  begin nxt_res = opnd_a;   nxt_evt = 1'b0;    end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= nxt_res;
    end

    sat_sticky u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (nxt_evt),
        .clr_i  (flag_clr),
        .flag_o (sat_flag)
    );

    assign result = res_q;
endmodule

// File: rtl/sat_arith_chk.sv
module sat_arith_chk
    import sat_arith_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic [SH_W-1:0]   sat_width,
    input logic              flag_clr,
    input logic [DATA_W-1:0] result,
    input logic              sat_flag
);
    localparam logic [DATA_W-1:0] SMAX   = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] DBL_HI = {2'b01, {(DATA_W-2){1'b0}}};

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !flag_clr) |=> sat_flag);

    // R9
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !op_is_defined(op_sel)) |=> !sat_flag);

    // R10
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_is_defined(op_sel) |=> (result == $past(opnd_a)));

    // R10
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_is_defined(op_sel) && !flag_clr) |=> (sat_flag == $past(sat_flag)));

    // R4
    dbl_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_DBL && $signed(opnd_a) >= $signed(DBL_HI))
        |=> (result == SMAX && sat_flag));

    // R3
    uadd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_UADD) |=> (result >= $past(opnd_a)));

    // R3
    usub_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_USUB) |=> (result <= $past(opnd_a)));

    // R7
    usat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_USATW)
        |=> (result <= ~({DATA_W{1'b1}} << $past(sat_width))));
endmodule

bind sat_arith_unit sat_arith_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) u_chk (.*);

// File: tb/tb_sat_arith_unit.sv
module tb_sat_arith_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  sat_width = '0;
    logic        flag_clr = 1'b0;
    logic [31:0] result;
    logic        sat_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    sat_arith_unit #(.DATA_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .sat_width(sat_width), .flag_clr(flag_clr),
        .result(result), .sat_flag(sat_flag)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [4:0] w, input logic clr,
                          input logic [31:0] exp_r, input logic exp_f);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; sat_width = w; flag_clr = clr;
        @(negedge clk);
        chk({tag, " result"}, result, exp_r);
        chk({tag, " flag"}, {31'd0, sat_flag}, {31'd0, exp_f});
        op_sel = 4'd0; opnd_a = '0; opnd_b = '0; sat_width = '0; flag_clr = 1'b0;
    endtask

    task automatic clear_flag(input string tag);
        @(negedge clk);
        op_sel = 4'd0; flag_clr = 1'b1;
        @(negedge clk);
        chk({tag, " clear"}, {31'd0, sat_flag}, 32'd0);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        // R1
        chk("R1 reset result", result, 32'd0);
        chk("R1 reset flag", {31'd0, sat_flag}, 32'd0);
    endtask

    task automatic t_signed_addsub();
        clear_flag("R9");
        run_op("R2 sadd plain", 4'd1, 32'd5, 32'd7, 5'd0, 1'b0, 32'd12, 1'b0);
        run_op("R2 sadd pos ovf", 4'd1, 32'h7FFFFFFF, 32'd1, 5'd0, 1'b0, 32'h7FFFFFFF, 1'b1);
        clear_flag("R9");
        run_op("R2 sadd neg ovf", 4'd1, 32'h80000000, 32'hFFFFFFFF, 5'd0, 1'b0, 32'h80000000, 1'b1);
        clear_flag("R9");
        run_op("R2 ssub plain", 4'd2, 32'd10, 32'd3, 5'd0, 1'b0, 32'd7, 1'b0);
        run_op("R2 ssub neg ovf", 4'd2, 32'h80000000, 32'd1, 5'd0, 1'b0, 32'h80000000, 1'b1);
        clear_flag("R9");
        run_op("R2 ssub pos ovf", 4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b0, 32'h7FFFFFFF, 1'b1);
        clear_flag("R9");
    endtask

    task automatic t_unsigned_addsub();
        run_op("R3 uadd plain", 4'd3, 32'd1, 32'd2, 5'd0, 1'b0, 32'd3, 1'b0);
        run_op("R3 uadd wrap", 4'd3, 32'hFFFFFFF0, 32'h20, 5'd0, 1'b0, 32'hFFFFFFFF, 1'b1);
        clear_flag("R9");
        run_op("R3 usub plain", 4'd4, 32'd9, 32'd4, 5'd0, 1'b0, 32'd5, 1'b0);
        run_op("R3 usub under", 4'd4, 32'd3, 32'd5, 5'd0, 1'b0, 32'd0, 1'b1);
        clear_flag("R9");
    endtask

    task automatic t_double();
        run_op("R4 dbl below hi", 4'd5, 32'h3FFFFFFF, 32'd0, 5'd0, 1'b0, 32'h7FFFFFFE, 1'b0);
        run_op("R4 dbl above lo", 4'd5, 32'hC0000001, 32'd0, 5'd0, 1'b0, 32'h80000002, 1'b0);
        run_op("R4 dbl at hi", 4'd5, 32'h40000000, 32'd0, 5'd0, 1'b0, 32'h7FFFFFFF, 1'b1);
        clear_flag("R9");
        run_op("R4 dbl at lo", 4'd5, 32'hC0000000, 32'd0, 5'd0, 1'b0, 32'h80000000, 1'b1);
        clear_flag("R9");
    endtask

    task automatic t_wrap_add();
        run_op("R5 wadd plain", 4'd6, 32'd2, 32'd3, 5'd0, 1'b0, 32'd5, 1'b0);
        run_op("R5 wadd ovf", 4'd6, 32'h7FFFFFFF, 32'd1, 5'd0, 1'b0, 32'h80000000, 1'b1);
        clear_flag("R9");
    endtask

    task automatic t_sat_word();
        run_op("R6 ssat inside", 4'd7, 32'd100, 32'd0, 5'd8, 1'b0, 32'd100, 1'b0);
        run_op("R6 ssat at lo", 4'd7, 32'hFFFFFF00, 32'd0, 5'd8, 1'b0, 32'hFFFFFF00, 1'b0);
        run_op("R6 ssat high", 4'd7, 32'd300, 32'd0, 5'd8, 1'b0, 32'h000000FF, 1'b1);
        clear_flag("R9");
        run_op("R6 ssat low", 4'd7, 32'hFFFFFED4, 32'd0, 5'd8, 1'b0, 32'hFFFFFF00, 1'b1);
        clear_flag("R9");
        run_op("R7 usat inside", 4'd8, 32'd200, 32'd0, 5'd8, 1'b0, 32'd200, 1'b0);
        run_op("R7 usat high", 4'd8, 32'd300, 32'd0, 5'd8, 1'b0, 32'h000000FF, 1'b1);
        clear_flag("R9");
        run_op("R7 usat neg", 4'd8, 32'hFFFFFFFB, 32'd0, 5'd8, 1'b0, 32'd0, 1'b1);
        clear_flag("R9");
    endtask

    task automatic t_sat_half();
        run_op("R8 ssath none", 4'd9, 32'h0005FFFA, 32'd0, 5'd4, 1'b0, 32'h0005FFFA, 1'b0);
        run_op("R8 ssath hi clamp", 4'd9, 32'h0100FFF0, 32'd0, 5'd4, 1'b0, 32'h000FFFF0, 1'b1);
        clear_flag("R9");
        run_op("R8 ssath lo clamp", 4'd9, 32'h00038000, 32'd0, 5'd4, 1'b0, 32'h0003FFF0, 1'b1);
        clear_flag("R9");
        run_op("R8 usath none", 4'd10, 32'h00400080, 32'd0, 5'd8, 1'b0, 32'h00400080, 1'b0);
        run_op("R8 usath both", 4'd10, 32'hFFFF0123, 32'd0, 5'd8, 1'b0, 32'h000000FF, 1'b1);
        clear_flag("R9");
    endtask

    task automatic t_sticky();
        run_op("R9 set", 4'd1, 32'h7FFFFFFF, 32'd1, 5'd0, 1'b0, 32'h7FFFFFFF, 1'b1);
        run_op("R9 hold", 4'd1, 32'd1, 32'd1, 5'd0, 1'b0, 32'd2, 1'b1);
        clear_flag("R9");
        run_op("R9 set wins", 4'd3, 32'hFFFFFFFF, 32'd1, 5'd0, 1'b1, 32'hFFFFFFFF, 1'b1);
        clear_flag("R9");
    endtask

    task automatic t_unused();
        run_op("R10 code0 flag0", 4'd0, 32'h12345678, 32'd9, 5'd3, 1'b0, 32'h12345678, 1'b0);
        run_op("R10 code11 flag0", 4'd11, 32'hDEADBEEF, 32'd0, 5'd0, 1'b0, 32'hDEADBEEF, 1'b0);
        run_op("R10 setup", 4'd4, 32'd0, 32'd1, 5'd0, 1'b0, 32'd0, 1'b1);
        run_op("R10 code15 flag1", 4'd15, 32'hCAFEF00D, 32'hFFFFFFFF, 5'd1, 1'b0, 32'hCAFEF00D, 1'b1);
        clear_flag("R9");
    endtask

    task automatic t_latency();
        // R11
        run_op("R11 prior", 4'd0, 32'hA5A5A5A5, 32'd0, 5'd0, 1'b0, 32'hA5A5A5A5, 1'b0);
        @(negedge clk);
        op_sel = 4'd1; opnd_a = 32'd40; opnd_b = 32'd2;
        #1;
        chk("R11 before edge", result, 32'd0);
        @(negedge clk);
        chk("R11 after edge", result, 32'd42);
        op_sel = 4'd0; opnd_a = '0; opnd_b = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_signed_addsub();
        t_unsigned_addsub();
        t_double();
        t_wrap_add();
        t_sat_word();
        t_sat_half();
        t_sticky();
        t_unused();
        t_latency();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule